// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block sends the header of a LIN frame on one serial output. A single write of an identifier byte starts the whole header: a long dominant break with its recessive delimiter, the synch character, and then the identifier character. No further action is needed from the master between these three fields. The bit timing comes from a one-cycle `baud_tick` enable that some other block supplies. Each tick marks the boundary between two bits.

The block shows a transmit-ready flag and two sticky completion flags: one for the break and one for the identifier. A command input clears both flags. When automatic parity is enabled at the moment of the write, the block replaces the top two identifier bits with the protected-identifier parity before it sends the byte.

The control is a five-state machine:
- `ST_IDLE`: no header in progress. A write moves the machine to `ST_ARM`.
- `ST_ARM`: waits for the first tick. That tick moves it to `ST_BREAK`.
- `ST_BREAK`: sends the break. The tick that ends the delimiter moves it to `ST_SYNC`.
- `ST_SYNC`: sends the synch character. The tick that ends its stop bit moves it to `ST_IDENT`.
- `ST_IDENT`: sends the identifier. The tick that ends its stop bit returns it to `ST_IDLE`.

Top module: `lin_hdr_tx`

## Requirements
- R1: An `id_wr` pulse while the machine is in `ST_IDLE` starts a header, and `tx_ready` is low from the next cycle.
- R2: The first bit starts in the cycle after the first `baud_tick` that follows the write. The break is 13 bits at 0 followed by one delimiter bit at 1, and each bit lasts from one tick to the next.
- R3: Right after the delimiter, the synch character 0x55 is sent as one start bit (0), eight data bits LSB first, and one stop bit (1).
- R4: Right after the synch stop bit, the identifier byte is sent with the same framing.
- R5: `tx_ready` returns high in the cycle in which the identifier start bit begins on `txd`.
- R6: `brk_done` goes high in the cycle in which the synch start bit begins. `id_done` goes high in the cycle after the tick that ends the identifier stop bit.
- R7: Both flags stay high until a cycle with `clr_status` high clears them. If a flag is set in the same cycle as the clear, the set wins.
- R8: With `par_en` high at the write, bit 6 of the sent byte is ID0^ID1^ID2^ID4 and bit 7 is the inverse of ID1^ID3^ID4^ID5, taken from `id_data[5:0]`. With `par_en` low, the byte is sent unchanged.
- R9: After reset, and whenever no header is being sent, `txd` is 1. Reset also leaves `tx_ready` at 1 and both flags at 0.
- R10: An `id_wr` pulse while a header is in progress (any state other than `ST_IDLE`) is ignored, and the header in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at each bit boundary |
| id_wr | input | 1 | Identifier write strobe |
| id_data | input | 8 | Identifier byte |
| par_en | input | 1 | Replace bits 7:6 with computed parity |
| clr_status | input | 1 | Clears both completion flags |
| txd | output | 1 | Serial output, 1 is recessive |
| tx_ready | output | 1 | High when a new identifier can be taken |
| brk_done | output | 1 | Sticky flag: break has been sent |
| id_done | output | 1 | Sticky flag: identifier has been sent |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that at least one cycle separates two ticks. The break-low check and the field-length checks count ticks, not clock cycles, so they rely on this. `id_wr` and `clr_status` may arrive in any cycle, including in the middle of a header. The stimulus follows these rules by making the tick from a divider of two or more cycles. It also drives writes both while idle and while a header is in progress, and sends clears both between headers and in the middle of a header.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
    localparam int BRK_LOW   = 13;
    localparam int FRAME_W   = BRK_LOW + 1;
    localparam int CHAR_BITS = 10;
    localparam int CNT_W     = $clog2(FRAME_W);
    localparam logic [7:0] SYNC_CHAR = 8'h55;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_BREAK,
        ST_SYNC,
        ST_IDENT
    } hdr_state_t;

    function automatic logic [FRAME_W-1:0] char_frame(input logic [7:0] b);
        logic [FRAME_W-1:0] f;
        f = '1;
        f[CHAR_BITS-1:0] = {1'b1, b, 1'b0};
        return f;
    endfunction

    function automatic logic [FRAME_W-1:0] break_frame();
        logic [FRAME_W-1:0] f;
        f = '0;
        f[FRAME_W-1] = 1'b1;
        return f;
    endfunction
endpackage

// File: rtl/lin_hdr_parity.sv
module lin_hdr_parity (
    input  logic       par_en,
    input  logic [7:0] raw_id,
    output logic [7:0] prot_id
);
    logic p_lo, p_hi;

    always_comb begin
        p_lo = raw_id[0] ^ raw_id[1] ^ raw_id[2] ^ raw_id[4];
        p_hi = ~(raw_id[1] ^ raw_id[3] ^ raw_id[4] ^ raw_id[5]);
        prot_id = par_en ? {p_hi, p_lo, raw_id[5:0]} : raw_id;
    end
endmodule

// File: rtl/lin_hdr_shift.sv
module lin_hdr_shift #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] frame,
    output logic         txd
);
    logic [W-2:0] rest;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd  <= 1'b1;
            rest <= '1;
        end else if (load) begin
            txd  <= frame[0];
            rest <= frame[W-1:1];
        end else if (shift) begin
            txd  <= rest[0];
            rest <= {1'b1, rest[W-2:1]};
        end
    end
endmodule

// File: rtl/lin_hdr_ctrl.sv
module lin_hdr_ctrl
    import lin_hdr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               id_wr,
    input  logic [7:0]         id_prot,
    input  logic               clr_status,
    output logic               load,
    output logic               shift,
    output logic [FRAME_W-1:0] frame,
    output logic               tx_ready,
    output logic               brk_done,
    output logic               id_done,
    output hdr_state_t         st,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic [7:0]         id_q
);
    hdr_state_t st_nx;
    logic       accept;
    logic       field_end;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        unique case (st)
            ST_BREAK: last_idx = CNT_W'(BRK_LOW);
            default:  last_idx = CNT_W'(CHAR_BITS - 1);
        endcase
    end

    assign accept    = (st == ST_IDLE) && id_wr;
    assign field_end = baud_tick && (bit_cnt == last_idx);

    always_comb begin
        st_nx = st;
        load  = 1'b0;
        shift = 1'b0;
        frame = '1;
        unique case (st)
            ST_IDLE:  if (accept) st_nx = ST_ARM;
            ST_ARM: if (baud_tick) begin
                st_nx = ST_BREAK;
                load  = 1'b1;
                frame = break_frame();
            end
            ST_BREAK: if (baud_tick) begin
                if (field_end) begin
                    st_nx = ST_SYNC;
                    load  = 1'b1;
                    frame = char_frame(SYNC_CHAR);
                end else shift = 1'b1;
            end
            ST_SYNC: if (baud_tick) begin
                if (field_end) begin
                    st_nx = ST_IDENT;
                    load  = 1'b1;
                    frame = char_frame(id_q);
                end else shift = 1'b1;
            end
            ST_IDENT: if (baud_tick) begin
                shift = 1'b1;
                if (field_end) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            id_q     <= '0;
            tx_ready <= 1'b1;
            brk_done <= 1'b0;
            id_done  <= 1'b0;
        end else begin
            if (load)       bit_cnt <= '0;
            else if (shift) bit_cnt <= bit_cnt + 1'b1;
            if (accept) id_q <= id_prot;
            if (accept)
                tx_ready <= 1'b0;
            else if (st == ST_SYNC && field_end)
                tx_ready <= 1'b1;
            if (st == ST_BREAK && field_end) brk_done <= 1'b1;
            else if (clr_status)             brk_done <= 1'b0;
            if (st == ST_IDENT && field_end) id_done <= 1'b1;
            else if (clr_status)             id_done <= 1'b0;
        end
    end
endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
    import lin_hdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       id_wr,
    input  logic [7:0] id_data,
    input  logic       par_en,
    input  logic       clr_status,
    output logic       txd,
    output logic       tx_ready,
    output logic       brk_done,
    output logic       id_done
);
    logic [7:0]         id_prot;
    logic               load, shift;
    logic [FRAME_W-1:0] frame;
    hdr_state_t         st;
    logic [CNT_W-1:0]   bit_cnt;
    logic [7:0]         id_q;

    lin_hdr_parity u_par (
        .par_en  (par_en),
        .raw_id  (id_data),
        .prot_id (id_prot)
    );

    lin_hdr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .id_wr      (id_wr),
        .id_prot    (id_prot),
        .clr_status (clr_status),
        .load       (load),
        .shift      (shift),
        .frame      (frame),
        .tx_ready   (tx_ready),
        .brk_done   (brk_done),
        .id_done    (id_done),
        .st         (st),
        .bit_cnt    (bit_cnt),
        .id_q       (id_q)
    );

    lin_hdr_shift #(.W(FRAME_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .frame (frame),
        .txd   (txd)
    );
endmodule

// File: rtl/lin_hdr_tx_chk.sv
module lin_hdr_tx_chk
    import lin_hdr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             id_wr,
    input logic             clr_status,
    input logic             txd,
    input logic             tx_ready,
    input logic             brk_done,
    input logic             id_done,
    input hdr_state_t       st,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [7:0]       id_q
);
    AST_WR_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (id_wr && st == ST_IDLE) |=> !tx_ready); // R1
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BREAK && bit_cnt < CNT_W'(BRK_LOW)) |-> !txd); // R2
    AST_SYNC_AFTER_BRK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_done) |-> (!txd && st == ST_SYNC)); // R6
    AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_done && !clr_status) |=> brk_done); // R7
    AST_ID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (id_done && !clr_status) |=> id_done); // R7
    AST_CLR_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && st == ST_IDLE) |=> (!brk_done && !id_done)); // R7
    AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_ARM) |-> txd); // R9
    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (id_wr && st != ST_IDLE) |=> $stable(id_q)); // R10
endmodule

bind lin_hdr_tx lin_hdr_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_wr      (id_wr),
    .clr_status (clr_status),
    .txd        (txd),
    .tx_ready   (tx_ready),
    .brk_done   (brk_done),
    .id_done    (id_done),
    .st         (st),
    .bit_cnt    (bit_cnt),
    .id_q       (id_q)
);

// File: tb/lin_hdr_tx_bench.sv
module lin_hdr_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       id_wr = 1'b0;
    logic [7:0] id_data = '0;
    logic       par_en = 1'b0;
    logic       clr_status = 1'b0;
    logic       txd, tx_ready, brk_done, id_done;

    int n_run = 0;
    int n_fail = 0;
    int tick_div = 4;
    int tick_cnt = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_active = 1'b0;
    bit m_armed = 1'b0;
    int m_idx = 0;
    int m_q[$];
    bit e_txd = 1'b1, e_rdy = 1'b1, e_brk = 1'b0, e_id = 1'b0;

    always #4 clk = ~clk;

    lin_hdr_tx u_lin_hdr_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .id_wr(id_wr),
        .id_data(id_data), .par_en(par_en), .clr_status(clr_status),
        .txd(txd), .tx_ready(tx_ready), .brk_done(brk_done), .id_done(id_done)
    );

    function automatic logic [7:0] protect(input logic [7:0] b, input bit en);
        logic [7:0] r;
        r = b;
        if (en) begin
            r[6] = b[0] ^ b[1] ^ b[2] ^ b[4];
            r[7] = ~(b[1] ^ b[3] ^ b[4] ^ b[5]);
        end
        return r;
    endfunction

    task automatic push_char(input logic [7:0] b);
        m_q.push_back(0);
        for (int i = 0; i < 8; i++) m_q.push_back(int'(b[i]));
        m_q.push_back(1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_armed = 0; m_idx = 0;
            e_txd = 1; e_rdy = 1; e_brk = 0; e_id = 0;
        end else begin
            bit set_b, set_i;
            set_b = 0; set_i = 0;
            if (!m_active && id_wr) begin
                m_active = 1; m_armed = 1; e_rdy = 0;
                m_q.delete();
                for (int i = 0; i < 13; i++) m_q.push_back(0);
                m_q.push_back(1);
                push_char(8'h55);
                push_char(protect(id_data, par_en));
            end else if (m_active && baud_tick) begin
                if (m_armed) begin
                    m_armed = 0; m_idx = 0; e_txd = m_q[0][0];
                end else begin
                    m_idx++;
                    if (m_idx == 14) set_b = 1;
                    if (m_idx == 24) e_rdy = 1;
                    if (m_idx == 34) begin
                        m_active = 0; set_i = 1; e_txd = 1;
                    end else e_txd = m_q[m_idx][0];
                end
            end
            if (clr_status) begin e_brk = 0; e_id = 0; end
            if (set_b) e_brk = 1;
            if (set_i) e_id = 1;
        end
    end

    task automatic check(input bit act, input bit exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0b expected %0b", what, cyc, act, exp);
        end
    endtask

    // Compare every cycle, then drive the baud tick
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(txd, e_txd, "R2 R3 R4 R8 R9 txd");
            check(tx_ready, e_rdy, "R1 R5 R10 tx_ready");
            check(brk_done, e_brk, "R6 R7 brk_done");
            check(id_done, e_id, "R6 R7 id_done");
        end
        tick_cnt++;
        baud_tick <= (tick_cnt % tick_div == 0);
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic pulse_wr(input logic [7:0] b, input bit pe);
        @(negedge clk);
        id_wr <= 1; id_data <= b; par_en <= pe;
        @(negedge clk);
        id_wr <= 0; par_en <= 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_status <= 1;
        @(negedge clk);
        clr_status <= 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_active) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        check(txd, 1'b1, "R9 reset txd");
        check(tx_ready, 1'b1, "R9 reset tx_ready");
        check(brk_done, 1'b0, "R9 reset brk_done");
        check(id_done, 1'b0, "R9 reset id_done");
        rst_n <= 1;
        repeat (2) @(negedge clk);
        // R1 R2 R3 R4: plain header
        pulse_wr(8'h3C, 0);
        wait_idle();
        check(id_done, 1'b1, "R6 id_done after header");
        pulse_clr();
        @(negedge clk);
        check(brk_done, 1'b0, "R7 cleared brk_done");
        // R8: parity on, two identifiers
        tick_div = 3;
        pulse_wr(8'h00, 1);
        wait_idle();
        pulse_wr(8'hFF, 1);
        // R10: write mid-header is ignored
        repeat (20) @(negedge clk);
        pulse_wr(8'hA5, 0);
        // R7: clear during the header
        repeat (60) @(negedge clk);
        pulse_clr();
        wait_idle();
        tick_div = 2;
        pulse_wr(8'h92, 0);
        repeat (40) @(negedge clk);
        pulse_wr(8'h11, 1);
        wait_idle();
        tick_div = 5;
        pulse_wr(8'h2B, 1);
        wait_idle();
        check(tx_ready, 1'b1, "R5 ready when idle");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule